// File: doc/BRIEF.md
# AC-link Reset and Clock Monitor

This block sits on the host side of a serial audio codec link. It samples the codec's bit clock with the host clock and reports when that clock has gone quiet. It drives the codec's cold reset line and the sync line, which is used here to request a warm reset. It also keeps one 32-bit global control and status word. That word mixes read-only, read/write and write-one-to-clear fields. The status fields record codec-ready and resume signalling from three serial data-in lines and changes on a bank of general-purpose inputs.

Software writes the whole word in one access and can read it back at any time. A warm reset request is accepted only while the bit clock is stopped. Once accepted, it keeps sync high until the bit clock runs again, and then it clears itself. A retention input models a power well that keeps the cold reset control bit alive across a block reset.

Top module: `aclk_link_ctl`

## Requirements
- R1: Bit 12 (clock stopped, read-only) reads 1 once four consecutive host cycles pass with no synchronised bit-clock transition, and reads 0 again as soon as a transition is detected.
- R2: The bit clock passes through a two-flop synchroniser, and a transition is detected by comparing two successive synchronised samples. A level change presented before host edge n is first counted at edge n+2.
- R3: Bit 2 is the active-low cold reset control. It resets to 0 and drives `codec_reset_n_o` directly. While it is 0, the ready bits are forced to 0 and any warm reset in progress is abandoned.
- R4: Writing 1 to bit 1 (warm reset) while the bit clock is running is ignored, and bit 1 stays 0.
- R5: An accepted warm reset keeps bit 1 and `codec_sync_o` at 1 until a bit-clock transition is detected, then clears both. Writing 0 to bit 1 has no effect.
- R6: Bits 6:4 (resume status, data-in lines 0 to 2) are set by a one-cycle pulse on `sdin_resume_i` and are cleared only by writing 1 to the bit.
- R7: Bits 10:8 (codec ready, lines 0 to 2) are read-only and show `sdin_ready_i` one host cycle later.
- R8: Any change on `gpi_i` sets bit 0 whatever the value of bit 3. Bit 3 is the GPI interrupt enable, and only when it is 1 does bit 0 raise `irq_o`.
- R9: After reset the word reads 0x00700000. Bits 31:30 and all other unused bits read 0, and bits 22:20 always read 1 (one per data-in line).
- R10: `irq_o` is a level. It stays high while bit 0 (with enable) or any resume bit is set, and it falls only after a software write.
- R11: When `keep_cold_i` is high during reset, bit 2 keeps its value instead of returning to 0.
- R12: Bit 0 is write-one-to-clear. A GPI change in the same cycle as the clearing write wins, and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keep_cold_i | input | 1 | Retention: hold the cold reset bit through reset |
| bit_clk_i | input | 1 | Codec bit clock, asynchronous |
| sdin_ready_i | input | 3 | Codec ready indication per data-in line |
| sdin_resume_i | input | 3 | One-cycle resume event per data-in line |
| gpi_i | input | NUM_GPI | General-purpose input values |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control and status word |
| codec_reset_n_o | output | 1 | Cold reset to codec, active low |
| codec_sync_o | output | 1 | Sync line, high during warm reset |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `gpi_i`, `sdin_ready_i` and `sdin_resume_i` are already synchronous to the host clock, and that each resume event lasts exactly one cycle. The bench therefore changes these inputs only on the falling host edge and drives a resume event for exactly one cycle. The bit clock is treated as asynchronous and can toggle at most once per host cycle. The bench changes it on the falling host edge, runs it at that maximum rate, and also stops it for long stretches so that the stop detector and the warm reset path are both exercised. Writes are single-cycle strobes and never overlap a reset.

// File: rtl/aclk_pkg.sv
// Shared constants for the link reset and clock monitor: word width,
// data-in line count and field positions of the control/status word.
package aclk_pkg;
    localparam int GSR_W       = 32;
    localparam int SDIN_N      = 3;
    localparam int B_GPI_STS   = 0;
    localparam int B_WARM      = 1;
    localparam int B_COLD_N    = 2;
    localparam int B_GPI_IE    = 3;
    localparam int B_RES_LO    = 4;
    localparam int B_RDY_LO    = 8;
    localparam int B_BCLK_STOP = 12;
    localparam int B_LINES_LO  = 20;
endpackage

// File: rtl/aclk_bclk_mon.sv
// Bit-clock activity monitor.
// Brings the asynchronous bit clock into the host domain through a
// SYNC_STAGES-deep flop chain and flags a transition whenever two
// successive synchronised samples differ. A saturating idle counter
// reports "stopped" after STOP_CYC host cycles without a transition.
// Assumes the bit clock toggles at most once per host cycle.
module aclk_bclk_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int STOP_CYC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk_i,
    output logic edge_o,
    output logic stopped_o
);
    localparam int CNT_W = $clog2(STOP_CYC + 1);
    localparam logic [CNT_W-1:0] STOP_V = CNT_W'(STOP_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic [CNT_W-1:0]       idle_q;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], bit_clk_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;

    // Idle run counter: restarts on a transition, saturates at STOP_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (edge_o) begin
            idle_q <= '0;
        end else if (idle_q != STOP_V) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign stopped_o = (idle_q == STOP_V);

    AST_EDGE_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !stopped_o); // R1
endmodule

// File: rtl/aclk_warm_seq.sv
// Warm reset sequencer.
// Accepts a software warm reset request only while the bit clock is
// stopped. Holds the request, which drives sync high, until the monitor
// reports a transition. A low cold reset control abandons it.
// Assumes set_req_i is a single-cycle write strobe.
module aclk_warm_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req_i,
    input  logic stopped_i,
    input  logic edge_i,
    input  logic cold_n_i,
    output logic warm_o
);
    logic warm_q;

    // Warm reset state: set when allowed, self-clear on bit-clock activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 1'b0;
        end else if (!cold_n_i) begin
            warm_q <= 1'b0;
        end else if (warm_q) begin
            warm_q <= !edge_i;
        end else begin
            warm_q <= set_req_i && stopped_i;
        end
    end

    assign warm_o = warm_q;

    AST_WARM_REJECT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req_i && !stopped_i && !warm_q) |=> !warm_q); // R4
    AST_WARM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && !edge_i && cold_n_i) |=> warm_q); // R5
    AST_COLD_ABORTS_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        !cold_n_i |=> !warm_q); // R3
endmodule

// File: rtl/aclk_gsr.sv
// Global control and status word.
// Holds the cold reset control (with retention through reset), the GPI
// interrupt enable, the sticky GPI-change and resume flags, and the ready
// mirror. Assembles the read word and the level interrupt.
// Assumes gpi_i, ready_i and resume_i are synchronous to clk.
module aclk_gsr
    import aclk_pkg::*;
#(
    parameter int NUM_GPI = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_cold_i,
    input  logic              wr_en_i,
    input  logic              wr_clr_gpi_i,
    input  logic              wr_cold_n_i,
    input  logic              wr_ie_i,
    input  logic [SDIN_N-1:0] wr_clr_res_i,
    input  logic [NUM_GPI-1:0] gpi_i,
    input  logic [SDIN_N-1:0] ready_i,
    input  logic [SDIN_N-1:0] resume_i,
    input  logic              warm_i,
    input  logic              stopped_i,
    output logic [GSR_W-1:0]  rd_data_o,
    output logic              cold_n_o,
    output logic              irq_o
);
    logic               cold_q;
    logic               ie_q;
    logic               gsts_q;
    logic [NUM_GPI-1:0] gpi_prev_q;
    logic [SDIN_N-1:0]  rdy_q;
    logic [SDIN_N-1:0]  res_q;
    logic               gpi_chg;

    assign gpi_chg = (gpi_i != gpi_prev_q);

    // Control bits: cold reset survives reset when retention is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cold_q <= keep_cold_i ? cold_q : 1'b0;
            ie_q   <= 1'b0;
        end else if (wr_en_i) begin
            cold_q <= wr_cold_n_i;
            ie_q   <= wr_ie_i;
        end
    end

    // GPI change flag: set on any input change, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gsts_q     <= 1'b0;
            gpi_prev_q <= gpi_i;
        end else begin
            gpi_prev_q <= gpi_i;
            if (gpi_chg) begin
                gsts_q <= 1'b1;
            end else if (wr_en_i && wr_clr_gpi_i) begin
                gsts_q <= 1'b0;
            end
        end
    end

    // Ready mirror: follows the data-in lines, forced low during cold reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '0;
        end else begin
            rdy_q <= cold_q ? ready_i : '0;
        end
    end

    // One sticky resume flag per data-in line.
    for (genvar i = 0; i < SDIN_N; i++) begin : g_res
        // Resume flag i: set by its event pulse, cleared by writing one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[i] <= 1'b0;
            end else if (resume_i[i]) begin
                res_q[i] <= 1'b1;
            end else if (wr_en_i && wr_clr_res_i[i]) begin
                res_q[i] <= 1'b0;
            end
        end

        AST_RES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (res_q[i] && !(wr_en_i && wr_clr_res_i[i])) |=> res_q[i]); // R6
    end

    // Read word assembly; unlisted bits read zero.
    always_comb begin
        rd_data_o = '0;
        rd_data_o[B_GPI_STS]   = gsts_q;
        rd_data_o[B_WARM]      = warm_i;
        rd_data_o[B_COLD_N]    = cold_q;
        rd_data_o[B_GPI_IE]    = ie_q;
        rd_data_o[B_BCLK_STOP] = stopped_i;
        for (int i = 0; i < SDIN_N; i++) begin
            rd_data_o[B_RES_LO + i]   = res_q[i];
            rd_data_o[B_RDY_LO + i]   = rdy_q[i];
            rd_data_o[B_LINES_LO + i] = 1'b1;
        end
    end

    assign cold_n_o = cold_q;
    assign irq_o    = (gsts_q && ie_q) || (|res_q);

    AST_GPI_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_clr_gpi_i && !gpi_chg) |=> !gsts_q); // R12
    AST_READY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        cold_q |=> (rdy_q == $past(ready_i))); // R7
    AST_READY_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cold_q |=> (rdy_q == '0)); // R3
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en_i)); // R10
endmodule

// File: rtl/aclk_link_ctl.sv
// Host-side link reset and clock monitor, top level.
// Ties the bit-clock monitor, the warm reset sequencer and the control
// word together and drives the codec reset and sync lines.
// Assumes single-cycle write strobes and host-synchronous status inputs.
module aclk_link_ctl
    import aclk_pkg::*;
#(
    parameter int NUM_GPI     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STOP_CYC    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               keep_cold_i,
    input  logic               bit_clk_i,
    input  logic [SDIN_N-1:0]  sdin_ready_i,
    input  logic [SDIN_N-1:0]  sdin_resume_i,
    input  logic [NUM_GPI-1:0] gpi_i,
    input  logic               wr_en_i,
    input  logic [GSR_W-1:0]   wr_data_i,
    output logic [GSR_W-1:0]   rd_data_o,
    output logic               codec_reset_n_o,
    output logic               codec_sync_o,
    output logic               irq_o
);
    logic bclk_edge;
    logic bclk_stopped;
    logic warm;
    logic cold_n;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data_i[GSR_W-1:B_RES_LO+SDIN_N]};

    aclk_bclk_mon #(
        .SYNC_STAGES(SYNC_STAGES),
        .STOP_CYC   (STOP_CYC)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_clk_i(bit_clk_i),
        .edge_o   (bclk_edge),
        .stopped_o(bclk_stopped)
    );

    aclk_warm_seq u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req_i(wr_en_i && wr_data_i[B_WARM]),
        .stopped_i(bclk_stopped),
        .edge_i   (bclk_edge),
        .cold_n_i (cold_n),
        .warm_o   (warm)
    );

    aclk_gsr #(
        .NUM_GPI(NUM_GPI)
    ) u_gsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .keep_cold_i (keep_cold_i),
        .wr_en_i     (wr_en_i),
        .wr_clr_gpi_i(wr_data_i[B_GPI_STS]),
        .wr_cold_n_i (wr_data_i[B_COLD_N]),
        .wr_ie_i     (wr_data_i[B_GPI_IE]),
        .wr_clr_res_i(wr_data_i[B_RES_LO +: SDIN_N]),
        .gpi_i       (gpi_i),
        .ready_i     (sdin_ready_i),
        .resume_i    (sdin_resume_i),
        .warm_i      (warm),
        .stopped_i   (bclk_stopped),
        .rd_data_o   (rd_data_o),
        .cold_n_o    (cold_n),
        .irq_o       (irq_o)
    );

    assign codec_reset_n_o = cold_n;
    assign codec_sync_o    = warm;
endmodule

// File: tb/tb_aclk_link_ctl.sv
// Bench: behavioural reference model updated on each rising edge,
// compared against the outputs on each falling edge.
module tb_aclk_link_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        keep_cold = 1'b0;
    logic        bit_clk = 1'b0;
    logic [2:0]  ready_in = '0;
    logic [2:0]  resume_in = '0;
    logic [7:0]  gpi = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rst_out_n, sync_out, irq;

    int  checks = 0;
    int  errors = 0;
    bit  run = 1'b0;
    bit  model_on = 1'b0;
    bit  done = 1'b0;

    // reference model state
    bit       m_cold, m_warm, m_gie, m_gsts;
    bit [2:0] m_res, m_rdy;
    int       m_idle;
    bit       q[$];
    bit [7:0] m_gprev;

    always #5 clk = ~clk;

    aclk_link_ctl dut (
        .clk(clk), .rst_n(rst_n), .keep_cold_i(keep_cold), .bit_clk_i(bit_clk),
        .sdin_ready_i(ready_in), .sdin_resume_i(resume_in), .gpi_i(gpi),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .codec_reset_n_o(rst_out_n), .codec_sync_o(sync_out), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Bit clock generator: one level change per host cycle while running.
    always @(negedge clk) if (run) bit_clk <= ~bit_clk;

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit e, sp, c_old;
        if (!rst_n) begin
            q = '{1'b0, 1'b0, 1'b0};
            m_idle = 0; m_warm = 0; m_gie = 0; m_gsts = 0; m_res = 0; m_rdy = 0;
            if (!keep_cold) m_cold = 0;
            m_gprev = gpi;
        end else begin
            e  = (q[q.size()-2] != q[q.size()-3]);
            sp = (m_idle >= 4);
            c_old = m_cold;
            if (!c_old)      m_warm = 0;
            else if (m_warm) m_warm = !e;
            else             m_warm = wr_en && wr_data[1] && sp;
            m_idle = e ? 0 : (m_idle < 4 ? m_idle + 1 : 4);
            m_rdy = c_old ? ready_in : 3'b000;
            if (gpi != m_gprev) m_gsts = 1;
            else if (wr_en && wr_data[0]) m_gsts = 0;
            m_gprev = gpi;
            for (int i = 0; i < 3; i++) begin
                if (resume_in[i]) m_res[i] = 1;
                else if (wr_en && wr_data[4+i]) m_res[i] = 0;
            end
            if (wr_en) begin m_cold = wr_data[2]; m_gie = wr_data[3]; end
            q.push_back(bit_clk);
            if (q.size() > 6) void'(q.pop_front());
        end
    end

    // Field-by-field comparison on each falling edge.
    always @(negedge clk) if (model_on && !done) begin
        chk("R1,R2 clock stopped", {31'd0, rd_data[12]}, {31'd0, m_idle >= 4});
        chk("R3 cold reset", {30'd0, rd_data[2], rst_out_n}, {30'd0, m_cold, m_cold});
        chk("R5 warm and sync", {30'd0, rd_data[1], sync_out}, {30'd0, m_warm, m_warm});
        chk("R6 resume flags", {29'd0, rd_data[6:4]}, {29'd0, m_res});
        chk("R7 ready mirror", {29'd0, rd_data[10:8]}, {29'd0, m_rdy});
        chk("R8 gpi status and enable", {30'd0, rd_data[3], rd_data[0]}, {30'd0, m_gie, m_gsts});
        chk("R9 fixed bits", rd_data & 32'hFFFF_E880, 32'h0070_0000);
        chk("R10 irq level", {31'd0, irq}, {31'd0, (m_gsts && m_gie) || (|m_res)});
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(posedge clk); model_on = 1'b1;
        cyc(3);
        chk("R9 reset word", rd_data, 32'h0070_0000);
        rst_n = 1'b1;
        run = 1'b1;
        cyc(6);
        wr(32'h0000_0004);                 // release cold reset
        cyc(4);
        wr(32'h0000_0006);                 // warm while running
        chk("R4 warm ignored while running", {31'd0, rd_data[1]}, 32'd0);
        ready_in = 3'b101;
        cyc(3);
        run = 1'b0;                        // stop bit clock
        cyc(8);
        wr(32'h0000_0006);                 // warm accepted
        cyc(5);
        chk("R5 sync held", {31'd0, sync_out}, 32'd1);
        wr(32'h0000_0004);                 // writing 0 to warm has no effect
        chk("R5 warm not cleared by write", {31'd0, rd_data[1]}, 32'd1);
        run = 1'b1;
        cyc(6);
        gpi = 8'h01;                       // change with enable off
        cyc(2);
        wr(32'h0000_0005);                 // clear bit 0
        wr(32'h0000_000C);                 // enable
        gpi = 8'h03;
        cyc(2);
        wr(32'h0000_000D);                 // clear, irq falls
        cyc(2);
        @(negedge clk); gpi = 8'h07; wr_en = 1'b1; wr_data = 32'h0000_000D;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        chk("R12 set beats clear", {31'd0, rd_data[0]}, 32'd1);
        wr(32'h0000_000D);
        @(negedge clk); resume_in = 3'b010;
        @(negedge clk); resume_in = 3'b000;
        cyc(3);
        wr(32'h0000_000C);                 // no clear bit: flag stays
        wr(32'h0000_002C);                 // clear resume line 1
        cyc(2);
        run = 1'b0;
        cyc(8);
        wr(32'h0000_000E);                 // warm again
        cyc(2);
        wr(32'h0000_0008);                 // cold reset aborts warm
        cyc(3);
        wr(32'h0000_000C);
        cyc(3);
        keep_cold = 1'b1; rst_n = 1'b0;    // retention through reset
        cyc(3);
        chk("R11 cold bit retained", {31'd0, rd_data[2]}, 32'd1);
        rst_n = 1'b1; keep_cold = 1'b0;
        run = 1'b1;
        cyc(5);
        finish_run();
    end
endmodule